// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the serial core of an SPI master. When its holding stage offers a word while the engine is idle, the engine loads the word into a transmit shift register and asserts the chosen active-low slave selects. After a setup interval, which can be lengthened, it produces a clock divided down from the system clock. Each sampling edge takes one bit in from `miso`, and each change edge puts one bit out on `mosi`. When the word ends, it releases the selects, shows the received word and pulses `done` for one cycle.

Clock polarity, clock phase, bit order, word width, divisor and select delay are elaboration parameters. The divisor is derived from the system clock rate and a target serial rate. The select delay is given in nanoseconds and rounded up to whole half periods of the serial clock. A mask register holds the set of slave lines to drive, and any number of them may be set. A force input holds the selected lines low across several words, so that frames longer than one word can be sent.

Top module: `spi_master_engine`

## Requirements
- R1: After reset every `ss_n` line is high, `sclk` is at its idle level, `busy` and `done` are low, `tx_ready` is high, and the select mask holds the value 1 (only line 0).
- R2: The serial clock half period is HALF = D/2 system cycles, where D is the smallest even divisor for which CLK_HZ/D does not exceed SCLK_HZ. `done` is set by the clock edge that comes HALF×(LEAD+2×DATA_W) edges after the edge that accepted the word.
- R3: `sclk` rests at CPOL whenever `busy` is low, and it toggles only during a word.
- R4: With CPHA=0, `miso` is sampled on the leading `sclk` edges and `mosi` changes on the trailing edges. With CPHA=1, `mosi` changes on the leading edges after the first one and `miso` is sampled on the trailing edges.
- R5: With LSB_FIRST=1, bit 0 of the word is sent and received first. With LSB_FIRST=0, bit DATA_W-1 goes first.
- R6: Each word is full duplex: exactly DATA_W sampling edges occur, and `rx_data` holds the bits from `miso`, assembled in the configured order. `rx_data` is valid from the cycle in which `done` is high.
- R7: The first `sclk` edge comes LEAD half periods after the accepting edge. LEAD = 1 + ceil(SS_DELAY_NS / half period in ns) when SS_DELAY_NS > 0, and LEAD = 1 otherwise.
- R8: During a word, `ss_n[i]` is low exactly when bit i of the mask is 1. A mask may have several bits set or none. A one-cycle `sel_wr` pulse loads `sel_mask_in` into the mask.
- R9: While `force_ss` is high, every line selected by the mask stays low, whether the engine is idle or between words.
- R10: Without `force_ss`, all `ss_n` lines return high one half period after the final `sclk` edge, on the same clock edge that raises `done`.
- R11: `done` lasts exactly one cycle. `busy` stays high from the accepting edge until the selects are released. A word is accepted only when `tx_valid` is high and the engine is idle, and `tx_valid` has no effect during a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Holding stage offers a word |
| tx_data | input | DATA_W | Word to transmit |
| tx_ready | output | 1 | Engine idle, word will be taken |
| rx_data | output | DATA_W | Last received word |
| done | output | 1 | One-cycle end-of-word pulse |
| busy | output | 1 | Word in progress (shift register not empty) |
| sel_wr | input | 1 | Load strobe for the select mask |
| sel_mask_in | input | NUM_SS | New select mask |
| force_ss | input | 1 | Hold masked selects low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
Two instances run side by side. One uses idle-low clock, leading-edge sampling, MSB first and no extra delay. The other uses idle-high clock, trailing-edge sampling, LSB first, an odd divisor half and an extra select delay. Both are swept through all 256 transmit words. A design that drops the first change edge wrong under trailing-edge sampling, or reverses the bit order, corrupts the word captured by the behavioural slave. A wrong divisor rounding or a wrong delay rounding moves the first clock edge and the `done` cycle away from the values computed arithmetically in the bench. The remaining cases are multi-bit and empty masks, forced select across three words, and a `tx_valid` pulse during a word. Each exposes lines that release early, drive unmasked slaves, or accept a second word mid-shift.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } eng_state_t;

  // Half serial period in system cycles: smallest even divisor not exceeding target rate.
  function automatic int unsigned half_cycles(longint unsigned clk_hz, longint unsigned sclk_hz);
    longint unsigned h;
    h = (clk_hz + 2 * sclk_hz - 1) / (2 * sclk_hz);
    if (h < 1) h = 1;
    return 32'(h);
  endfunction

  // Setup half periods before the first edge: one base half plus the rounded-up delay.
  function automatic int unsigned lead_halves(longint unsigned delay_ns, longint unsigned clk_hz,
                                              int unsigned half);
    longint unsigned num, den;
    if (delay_ns == 0) return 1;
    num = delay_ns * clk_hz;
    den = 64'd1_000_000_000 * half;
    return 32'(1 + (num + den - 1) / den);
  endfunction

endpackage

// File: rtl/spi_eng_tick.sv
module spi_eng_tick #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
  import spi_eng_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEADH  = 1,
  parameter bit          CPOL   = 1'b0,
  parameter bit          CPHA   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic busy,
  output logic sclk,
  output logic edge_ev,
  output logic sample_ev,
  output logic shift_ev,
  output logic done_ev
);
  localparam int unsigned NE = 2 * DATA_W;
  localparam int EW = $clog2(NE) + 1;
  localparam int LW = $clog2(LEADH) + 1;

  eng_state_t    st;
  logic [LW-1:0] hcnt;
  logic [EW-1:0] ecnt;
  logic          lead_end;
  logic [EW-1:0] eidx;
  logic          leading;

  assign busy     = (st != ST_IDLE);
  assign lead_end = tick && (st == ST_LEAD) && (hcnt == LW'(LEADH - 1));
  assign edge_ev  = lead_end || (tick && (st == ST_SHIFT));
  assign eidx     = (st == ST_SHIFT) ? ecnt : '0;
  assign leading  = ~eidx[0];
  assign done_ev  = tick && (st == ST_TAIL);

  generate
    if (CPHA) begin : g_ph1
      assign sample_ev = edge_ev && !leading;
      assign shift_ev  = edge_ev && leading && (eidx != '0);
    end else begin : g_ph0
      assign sample_ev = edge_ev && leading;
      assign shift_ev  = edge_ev && !leading;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      hcnt <= '0;
      ecnt <= '0;
      sclk <= CPOL;
    end else begin
      unique case (st)
        ST_IDLE: if (load) begin
          st   <= ST_LEAD;
          hcnt <= '0;
        end
        ST_LEAD: if (tick) begin
          if (lead_end) begin
            st   <= ST_SHIFT;
            ecnt <= EW'(1);
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        ST_SHIFT: if (tick) begin
          if (ecnt == EW'(NE - 1)) st <= ST_TAIL;
          else                     ecnt <= ecnt + 1'b1;
        end
        ST_TAIL: if (tick) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (edge_ev)            sclk <= ~sclk;
      else if (st == ST_IDLE) sclk <= CPOL;
    end
  end
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
  parameter int unsigned DATA_W    = 8,
  parameter bit          LSB_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              shift_ev,
  input  logic              sample_ev,
  input  logic              done_ev,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sh, rx_sh, tx_nxt, rx_nxt;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign tx_nxt = tx_sh >> 1;
      assign rx_nxt = (rx_sh >> 1) | (DATA_W'(miso) << (DATA_W - 1));
      assign mosi   = tx_sh[0];
    end else begin : g_msb
      assign tx_nxt = tx_sh << 1;
      assign rx_nxt = (rx_sh << 1) | DATA_W'(miso);
      assign mosi   = tx_sh[DATA_W-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_word <= '0;
    end else begin
      if (load)          tx_sh <= load_word;
      else if (shift_ev) tx_sh <= tx_nxt;
      if (sample_ev)     rx_sh <= rx_nxt;
      if (done_ev)       rx_word <= rx_sh;
    end
  end
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
#(
  parameter int unsigned     DATA_W      = 8,
  parameter int unsigned     NUM_SS      = 4,
  parameter longint unsigned CLK_HZ      = 100_000_000,
  parameter longint unsigned SCLK_HZ     = 25_000_000,
  parameter bit              CPOL        = 1'b0,
  parameter bit              CPHA        = 1'b0,
  parameter bit              LSB_FIRST   = 1'b0,
  parameter longint unsigned SS_DELAY_NS = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              done,
  output logic              busy,
  input  logic              sel_wr,
  input  logic [NUM_SS-1:0] sel_mask_in,
  input  logic              force_ss,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n
);
  localparam int unsigned HALF  = half_cycles(CLK_HZ, SCLK_HZ);
  localparam int unsigned LEADH = lead_halves(SS_DELAY_NS, CLK_HZ, HALF);

  // Named internal events, visible to the bound checker.
  logic              load;
  logic              tick;
  logic              edge_ev;
  logic              sample_ev;
  logic              shift_ev;
  logic              done_ev;
  logic [NUM_SS-1:0] sel_mask;

  assign tx_ready = ~busy;
  assign load     = tx_valid && tx_ready;
  assign ss_n     = ~(sel_mask & {NUM_SS{busy | force_ss}});

  spi_eng_tick #(.HALF(HALF)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  spi_eng_seq #(
    .DATA_W(DATA_W), .LEADH(LEADH), .CPOL(CPOL), .CPHA(CPHA)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .tick     (tick),
    .busy     (busy),
    .sclk     (sclk),
    .edge_ev  (edge_ev),
    .sample_ev(sample_ev),
    .shift_ev (shift_ev),
    .done_ev  (done_ev)
  );

  spi_eng_shift #(.DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_word(tx_data),
    .shift_ev (shift_ev),
    .sample_ev(sample_ev),
    .done_ev  (done_ev),
    .miso     (miso),
    .mosi     (mosi),
    .rx_word  (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_mask <= NUM_SS'(1);
      done     <= 1'b0;
    end else begin
      if (sel_wr) sel_mask <= sel_mask_in;
      done <= done_ev;
    end
  end
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk #(
  parameter int unsigned NUM_SS = 4,
  parameter bit          CPOL   = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic [NUM_SS-1:0] ss_n,
  input logic [NUM_SS-1:0] mask_q,
  input logic              busy,
  input logic              done,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              force_ss,
  input logic              edge_ev
);
  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == CPOL));

  assert_clk_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> $past(busy));

  assert_edge_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ev |=> (sclk != $past(sclk)));

  assert_unmasked_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    &(ss_n | mask_q));

  assert_forced_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_ss |-> ((~ss_n) == mask_q));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !force_ss) |-> (&ss_n));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> busy);
endmodule

bind spi_master_engine spi_eng_chk #(.NUM_SS(NUM_SS), .CPOL(CPOL)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sclk    (sclk),
  .ss_n    (ss_n),
  .mask_q  (sel_mask),
  .busy    (busy),
  .done    (done),
  .tx_valid(tx_valid),
  .tx_ready(tx_ready),
  .force_ss(force_ss),
  .edge_ev (edge_ev)
);

// File: tb/tb_spi_slave_model.sv
module tb_spi_slave_model #(
  parameter int W    = 8,
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0,
  parameter bit LSB  = 1'b0
) (
  input  logic         sclk,
  input  logic         sel_n,
  input  logic         mosi,
  input  logic [W-1:0] drive_word,
  output logic         miso,
  output logic [W-1:0] cap,
  output int           nsamp
);
  int         idx    = 0;
  int         cnt    = 0;
  logic [W-1:0] cap_r = '0;

  assign miso  = drive_word[LSB ? idx : (W - 1 - idx)];
  assign cap   = cap_r;
  assign nsamp = cnt;

  always @(sclk) begin : edge_b
    logic lead;
    if (sel_n === 1'b0) begin
      lead = (sclk != CPOL);
      if (CPHA ? !lead : lead) begin
        cap_r = LSB ? {mosi, cap_r[W-1:1]} : {cap_r[W-2:0], mosi};
        idx   = (idx == W - 1) ? 0 : idx + 1;
        cnt   = cnt + 1;
      end
    end
  end
endmodule

// File: tb/tb_spi_master_engine.sv
module tb_spi_master_engine;
  localparam int W  = 8;
  localparam int NS = 4;
  localparam longint CLK    = 100_000_000;
  localparam longint SCLK_A = 30_000_000;
  localparam longint SCLK_B = 20_000_000;
  localparam bit CPOL_A = 0, CPHA_A = 0, LSB_A = 0;
  localparam bit CPOL_B = 1, CPHA_B = 1, LSB_B = 1;
  localparam longint DLY_A = 0;
  localparam longint DLY_B = 35;
  localparam int LIMIT = 150000;

  // Expected timing restated arithmetically.
  function automatic int exp_half(longint target);
    longint d = 2;
    while (CLK > target * d) d += 2;
    return int'(d / 2);
  endfunction
  function automatic int exp_lead(longint dly, int half);
    longint h = 0;
    while (h * half * 64'd1_000_000_000 < dly * CLK) h++;
    return int'(1 + h);
  endfunction

  localparam int HA = exp_half(SCLK_A);
  localparam int HB = exp_half(SCLK_B);
  localparam int LA = exp_lead(DLY_A, HA);
  localparam int LB = exp_lead(DLY_B, HB);

  logic clk = 0;
  logic rst_n = 0;
  logic tx_valid = 0;
  logic [W-1:0] tx_data = '0;
  logic sel_wr = 0;
  logic [NS-1:0] sel_in = '0;
  logic force_ss = 0;
  logic [W-1:0] rxw = '0;

  logic rdy_a, done_a, busy_a, sclk_a, mosi_a, miso_a;
  logic rdy_b, done_b, busy_b, sclk_b, mosi_b, miso_b;
  logic [W-1:0] rx_a, rx_b, cap_a, cap_b;
  logic [NS-1:0] ssn_a, ssn_b;
  int ns_a, ns_b;

  always #5 clk = ~clk;

  spi_master_engine #(.DATA_W(W), .NUM_SS(NS), .CLK_HZ(CLK), .SCLK_HZ(SCLK_A),
    .CPOL(CPOL_A), .CPHA(CPHA_A), .LSB_FIRST(LSB_A), .SS_DELAY_NS(DLY_A)) dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(rdy_a),
    .rx_data(rx_a), .done(done_a), .busy(busy_a), .sel_wr(sel_wr), .sel_mask_in(sel_in),
    .force_ss(force_ss), .sclk(sclk_a), .mosi(mosi_a), .miso(miso_a), .ss_n(ssn_a));

  spi_master_engine #(.DATA_W(W), .NUM_SS(NS), .CLK_HZ(CLK), .SCLK_HZ(SCLK_B),
    .CPOL(CPOL_B), .CPHA(CPHA_B), .LSB_FIRST(LSB_B), .SS_DELAY_NS(DLY_B)) dut_b (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(rdy_b),
    .rx_data(rx_b), .done(done_b), .busy(busy_b), .sel_wr(sel_wr), .sel_mask_in(sel_in),
    .force_ss(force_ss), .sclk(sclk_b), .mosi(mosi_b), .miso(miso_b), .ss_n(ssn_b));

  tb_spi_slave_model #(.W(W), .CPOL(CPOL_A), .CPHA(CPHA_A), .LSB(LSB_A)) mdl_a (
    .sclk(sclk_a), .sel_n(&ssn_a), .mosi(mosi_a), .drive_word(rxw),
    .miso(miso_a), .cap(cap_a), .nsamp(ns_a));

  tb_spi_slave_model #(.W(W), .CPOL(CPOL_B), .CPHA(CPHA_B), .LSB(LSB_B)) mdl_b (
    .sclk(sclk_b), .sel_n(&ssn_b), .mosi(mosi_b), .drive_word(rxw),
    .miso(miso_b), .cap(cap_b), .nsamp(ns_b));

  // Timing monitor: cycles from accepting edge to first sclk change and to done.
  int cyc = 0;
  int tl_a = 0, tl_b = 0, first_a = 0, first_b = 0, lat_a = 0, lat_b = 0;
  int dc_a = 0, dc_b = 0;
  bit seen_a = 0, seen_b = 0;
  logic sp_a = CPOL_A, sp_b = CPOL_B;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    sp_a <= sclk_a;
    sp_b <= sclk_b;
    if (tx_valid && rdy_a) begin tl_a <= cyc; seen_a <= 0; end
    if (tx_valid && rdy_b) begin tl_b <= cyc; seen_b <= 0; end
    if (!seen_a && busy_a && sclk_a != sp_a) begin first_a <= cyc - tl_a; seen_a <= 1; end
    if (!seen_b && busy_b && sclk_b != sp_b) begin first_b <= cyc - tl_b; seen_b <= 1; end
    if (done_a) begin lat_a <= cyc - tl_a; dc_a <= dc_a + 1; end
    if (done_b) begin lat_b <= cyc - tl_b; dc_b <= dc_b + 1; end
  end

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_mask(input logic [NS-1:0] m);
    @(negedge clk);
    sel_wr = 1; sel_in = m;
    @(negedge clk);
    sel_wr = 0;
  endtask

  task automatic xfer(input logic [W-1:0] w, input logic [W-1:0] r, input logic [NS-1:0] m,
                      input bit glitch, input bit frc);
    int a0, b0, na0, nb0;
    @(negedge clk);
    rxw = r; tx_data = w; tx_valid = 1;
    a0 = dc_a; b0 = dc_b; na0 = ns_a; nb0 = ns_b;
    @(negedge clk);
    tx_valid = 0;
    repeat (4) @(negedge clk);
    chk(ssn_a == ~m, "R8 select lines A", ssn_a, ~m);
    chk(ssn_b == ~m, "R8 select lines B", ssn_b, ~m);
    chk(busy_a && busy_b && !rdy_a && !rdy_b, "R11 busy during word",
        {busy_a, busy_b, rdy_a, rdy_b}, 4'b1100);
    if (glitch) begin
      tx_valid = 1; tx_data = ~w;
      @(negedge clk);
      tx_valid = 0; tx_data = w;
    end
    while (dc_a == a0 || dc_b == b0) @(negedge clk);
    if (m != '0) begin
      chk(rx_a == r, "R6 received word A", rx_a, r);
      chk(rx_b == r, "R6 received word B", rx_b, r);
      chk(cap_a == w, "R4 R5 sent word A (phase0 MSB)", cap_a, w);
      chk(cap_b == w, "R4 R5 sent word B (phase1 LSB)", cap_b, w);
      chk(ns_a - na0 == W, "R6 sample edges A", ns_a - na0, W);
      chk(ns_b - nb0 == W, "R6 sample edges B", ns_b - nb0, W);
    end
    chk(first_a == HA * LA + 1, "R7 first edge A", first_a, HA * LA + 1);
    chk(first_b == HB * LB + 1, "R7 first edge B", first_b, HB * LB + 1);
    chk(lat_a == HA * (LA + 2 * W) + 1, "R2 done timing A", lat_a, HA * (LA + 2 * W) + 1);
    chk(lat_b == HB * (LB + 2 * W) + 1, "R2 done timing B", lat_b, HB * (LB + 2 * W) + 1);
    chk(dc_a - a0 == 1 && dc_b - b0 == 1, "R11 one word per accept",
        dc_a - a0 + dc_b - b0, 2);
    if (frc) begin
      chk(ssn_a == ~m && ssn_b == ~m, "R9 held between words", {ssn_a, ssn_b}, {~m, ~m});
    end else begin
      chk(&ssn_a && &ssn_b, "R10 released after word", {ssn_a, ssn_b}, 8'hFF);
    end
    chk(sclk_a == CPOL_A && sclk_b == CPOL_B, "R3 idle level", {sclk_a, sclk_b},
        {CPOL_A, CPOL_B});
    chk(!busy_a && !busy_b && rdy_a && rdy_b && !done_a && !done_b, "R11 idle after done",
        {busy_a, busy_b, rdy_a, rdy_b, done_a, done_b}, 6'b001100);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(&ssn_a && &ssn_b, "R1 selects high", {ssn_a, ssn_b}, 8'hFF);
    chk(sclk_a == CPOL_A && sclk_b == CPOL_B, "R1 idle sclk", {sclk_a, sclk_b},
        {CPOL_A, CPOL_B});
    chk(!busy_a && !busy_b && !done_a && !done_b && rdy_a && rdy_b, "R1 flags",
        {busy_a, busy_b, done_a, done_b, rdy_a, rdy_b}, 6'b000011);
    // Exhaustive word sweep with reset mask (R1 mask value 1)
    for (int w = 0; w < 256; w++) begin
      xfer(8'(w), 8'((w * 37 + 11) & 255), 4'b0001, (w == 7), 1'b0);
    end
    // R8 multi-bit and empty masks
    set_mask(4'b1010);
    xfer(8'hC3, 8'h3C, 4'b1010, 1'b0, 1'b0);
    set_mask(4'b0110);
    xfer(8'h81, 8'h7E, 4'b0110, 1'b0, 1'b0);
    set_mask(4'b0000);
    xfer(8'h55, 8'hAA, 4'b0000, 1'b0, 1'b0);
    // R9 forced select across a three-word frame
    set_mask(4'b0011);
    @(negedge clk);
    force_ss = 1;
    @(negedge clk);
    chk(ssn_a == 4'b1100 && ssn_b == 4'b1100, "R9 forced while idle", {ssn_a, ssn_b}, 8'hCC);
    xfer(8'h12, 8'hED, 4'b0011, 1'b0, 1'b1);
    xfer(8'h34, 8'hCB, 4'b0011, 1'b0, 1'b1);
    xfer(8'h56, 8'hA9, 4'b0011, 1'b0, 1'b1);
    @(negedge clk);
    force_ss = 0;
    @(negedge clk);
    chk(&ssn_a && &ssn_b, "R10 released with force low", {ssn_a, ssn_b}, 8'hFF);
  endtask

  initial begin
    bit timeout;
    timeout = 0;
    fork
      run_all();
      begin
        repeat (LIMIT) @(posedge clk);
        timeout = 1;
      end
    join_any
    if (timeout) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R2: actual %0d cycles expected completion", LIMIT);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule